// File: doc/BRIEF.md
# Fractional-Rate Real-Time Counter

This block is a free-running 64-bit time base whose count rate stays the same when the clock that drives it changes frequency. It does not add one per input clock. On every clock it adds a programmable numerator to a small remainder accumulator. Whenever the running sum reaches a programmable denominator, it takes the denominator off the sum and moves the count forward by one. The count therefore advances at the input frequency times numerator over denominator. With the right pair for each supported input clock, that gives 6.144 MHz. The pairs are 4/25 at 38.4 MHz, 8/25 at 19.2 MHz, 192/625 at 20 MHz, 64/125 at 12 MHz, 768/1625 at 13 MHz, 384/1625 at 26 MHz and 256/1125 at 27 MHz.

Software sets the ratio through two 32-bit registers. Only the low 12 bits of each register form the ratio. The upper 20 bits are plain storage that reads back as written. A rate-switch strobe loads a new pair into both ratio fields in one clock, so that clocking logic outside the block can retune the ratio when it changes the source clock. The count is never stopped or reloaded. Consumers see the count value and a one-cycle strobe for each advance.

Top module: `frac_rate_counter`

## Requirements
- R1: Reset (synchronous, active high) clears the count, the tick strobe and the remainder. The ratio resets to 4/25, so the numerator register reads 0x00000004 and the denominator register reads 0x00000019.
- R2: With a numerator n no larger than a nonzero denominator d, N clocks after the remainder was cleared the count has grown by exactly floor(N*n/d). Example: 4/25 gives 160 counts in 1000 clocks.
- R3: The count grows by at most one per clock. `tick` is high in exactly those cycles where the count holds a value one above the previous cycle's value.
- R4: The numerator register sits at address 0x10 and the denominator register at 0x14, with the ratio in bits [11:0]. Bits [31:12] store the written value and read back unchanged, but have no effect on the rate.
- R5: A ratio load is a register write to either ratio address or a rate-switch strobe. On the clock edge that takes the load, the count still advances by the old ratio and the remainder is cleared. The new ratio governs from the next edge on.
- R6: A `rate_sw` pulse copies `rate_num` and `rate_den` into bits [11:0] of the two registers, and bits [31:12] are kept. In the same cycle as a register write, the strobe's fields win over the written low bits, while the written upper bits are still stored.
- R7: If the numerator exceeds the denominator, or the denominator is zero, the count advances on every clock. The remainder always stays below a nonzero denominator.
- R8: Writes to any address other than 0x10 and 0x14 change neither register and do not clear the remainder. Reads of other addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, whose frequency may vary |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| rate_sw | input | 1 | Rate-switch strobe; loads `rate_num`/`rate_den` |
| rate_num | input | 12 | Numerator taken on `rate_sw` |
| rate_den | input | 12 | Denominator taken on `rate_sw` |
| count | output | 64 | Free-running count value |
| tick | output | 1 | High for one cycle each time `count` advances |

## Verification
A step that is decided at a clock edge shows up in `count` and `tick` right after that same edge, because each passes through one register. A ratio load clears the remainder at its own edge and takes effect at the following edge. `reg_rdata` is combinational and is read a short delay after the address changes. The bench drives all inputs and samples all outputs on the falling edge. It takes a reference count immediately after the last load edge of a scenario, then counts rising edges and compares the count with the floor formula from that reference. This places every edge, including the load edge, on a known side of the reference.

// File: rtl/frac_cnt_pkg.sv
package frac_cnt_pkg;

    // Ratio field width, register width and address width
    parameter int RATIO_W = 12;
    parameter int REG_W   = 32;
    parameter int ADDR_W  = 8;

    localparam int SUM_W   = RATIO_W + 1;
    localparam int UPPER_W = REG_W - RATIO_W;

    typedef logic [RATIO_W-1:0] frac_t;

    // Active ratio pair
    typedef struct packed {
        frac_t num;
        frac_t den;
    } ratio_t;

    // Layout of one ratio register: stored upper bits, ratio field below
    typedef struct packed {
        logic [UPPER_W-1:0] keep;
        frac_t              field;
    } ratio_reg_t;

    // Numerator limited to the denominator, so at most one step per clock
    function automatic frac_t clamp_num(ratio_t r);
        return (r.num > r.den) ? r.den : r.num;
    endfunction

endpackage

// File: rtl/frac_cnt_regs.sv
module frac_cnt_regs
    import frac_cnt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] NUM_ADDR = 8'h10,
    parameter logic [ADDR_W-1:0] DEN_ADDR = 8'h14,
    parameter frac_t             RST_NUM  = 12'd4,
    parameter frac_t             RST_DEN  = 12'd25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              rate_sw,
    input  frac_t             rate_num,
    input  frac_t             rate_den,
    output ratio_t            ratio,
    output logic              load
);

    ratio_reg_t num_q, num_d;
    ratio_reg_t den_q, den_d;
    logic       hit_num, hit_den;

    assign hit_num = reg_wr && (reg_addr == NUM_ADDR);
    assign hit_den = reg_wr && (reg_addr == DEN_ADDR);
    assign load    = rate_sw || hit_num || hit_den;

    always_comb begin
        num_d = num_q;
        den_d = den_q;
        if (hit_num) begin
            num_d = ratio_reg_t'(reg_wdata);
        end
        if (hit_den) begin
            den_d = ratio_reg_t'(reg_wdata);
        end
        // The strobe owns the ratio fields; stored upper bits stay
        if (rate_sw) begin
            num_d.field = rate_num;
            den_d.field = rate_den;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            num_q <= '{keep: '0, field: RST_NUM};
            den_q <= '{keep: '0, field: RST_DEN};
        end else begin
            num_q <= num_d;
            den_q <= den_d;
        end
    end

    always_comb begin
        if (reg_addr == NUM_ADDR) begin
            reg_rdata = REG_W'(num_q);
        end else if (reg_addr == DEN_ADDR) begin
            reg_rdata = REG_W'(den_q);
        end else begin
            reg_rdata = '0;
        end
    end

    assign ratio = '{num: num_q.field, den: den_q.field};

endmodule

// File: rtl/frac_cnt_accum.sv
module frac_cnt_accum
    import frac_cnt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ratio_t ratio,
    input  logic   load,
    output logic   step,
    output frac_t  acc
);

    frac_t            acc_q;
    frac_t            num_eff;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] den_ext;
    logic [SUM_W-1:0] wrap;

    always_comb begin
        num_eff = clamp_num(ratio);
        sum     = {1'b0, acc_q} + {1'b0, num_eff};
        den_ext = {1'b0, ratio.den};
        step    = (sum >= den_ext);
        wrap    = step ? (sum - den_ext) : sum;
    end

    // A load clears the remainder; this edge's step still uses the old ratio
    always_ff @(posedge clk) begin
        if (rst || load) begin
            acc_q <= '0;
        end else begin
            acc_q <= wrap[RATIO_W-1:0];
        end
    end

    assign acc = acc_q;

endmodule

// File: rtl/frac_cnt_counter.sv
module frac_cnt_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             tick
);

    logic [CNT_W-1:0] count_q;
    logic             tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            tick_q  <= 1'b0;
        end else begin
            count_q <= count_q + CNT_W'(step);
            tick_q  <= step;
        end
    end

    assign count = count_q;
    assign tick  = tick_q;

endmodule

// File: rtl/frac_rate_counter.sv
module frac_rate_counter
    import frac_cnt_pkg::*;
#(
    parameter int                CNT_W    = 64,
    parameter logic [ADDR_W-1:0] NUM_ADDR = 8'h10,
    parameter logic [ADDR_W-1:0] DEN_ADDR = 8'h14,
    parameter frac_t             RST_NUM  = 12'd4,
    parameter frac_t             RST_DEN  = 12'd25
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               rate_sw,
    input  logic [RATIO_W-1:0] rate_num,
    input  logic [RATIO_W-1:0] rate_den,
    output logic [CNT_W-1:0]   count,
    output logic               tick
);

    ratio_t ratio_q;
    logic   ratio_load;
    logic   step;
    frac_t  acc_q;
    frac_t  act_num;
    frac_t  act_den;

    frac_cnt_regs #(
        .NUM_ADDR (NUM_ADDR),
        .DEN_ADDR (DEN_ADDR),
        .RST_NUM  (RST_NUM),
        .RST_DEN  (RST_DEN)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rate_sw   (rate_sw),
        .rate_num  (rate_num),
        .rate_den  (rate_den),
        .ratio     (ratio_q),
        .load      (ratio_load)
    );

    frac_cnt_accum u_accum (
        .clk   (clk),
        .rst   (rst),
        .ratio (ratio_q),
        .load  (ratio_load),
        .step  (step),
        .acc   (acc_q)
    );

    frac_cnt_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .count (count),
        .tick  (tick)
    );

    assign act_num = ratio_q.num;
    assign act_den = ratio_q.den;

endmodule

// File: rtl/frac_rate_counter_chk.sv
module frac_rate_counter_chk
    import frac_cnt_pkg::*;
#(
    parameter int                CNT_W    = 64,
    parameter logic [ADDR_W-1:0] NUM_ADDR = 8'h10,
    parameter logic [ADDR_W-1:0] DEN_ADDR = 8'h14
) (
    input logic              clk,
    input logic              rst,
    input logic [CNT_W-1:0]  count,
    input logic              tick,
    input frac_t             acc,
    input frac_t             act_num,
    input frac_t             act_den,
    input logic              load,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              rate_sw
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count == '0 && !tick && acc == '0));

    // R3
    step_le_one_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (count == $past(count) || count == $past(count) + CNT_W'(1)));

    // R3
    tick_pairs_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (tick == (count != $past(count))));

    // R5
    load_clears_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (acc == '0));

    // R7
    acc_below_den_chk: assert property (@(posedge clk) disable iff (rst)
        (act_den != '0) |-> (acc < act_den));

    // R7
    full_rate_chk: assert property (@(posedge clk) disable iff (rst)
        (act_num >= act_den) |=> tick);

    // R8
    stray_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !rate_sw && reg_addr != NUM_ADDR && reg_addr != DEN_ADDR)
        |=> ($stable(act_num) && $stable(act_den)));

endmodule

bind frac_rate_counter frac_rate_counter_chk #(
    .CNT_W    (CNT_W),
    .NUM_ADDR (NUM_ADDR),
    .DEN_ADDR (DEN_ADDR)
) i_frac_rate_counter_chk (
    .clk      (clk),
    .rst      (rst),
    .count    (count),
    .tick     (tick),
    .acc      (acc_q),
    .act_num  (act_num),
    .act_den  (act_den),
    .load     (ratio_load),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .rate_sw  (rate_sw)
);

// File: tb/test_frac_rate_counter.sv
module test_frac_rate_counter;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 64;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_wr = 1'b0;
    logic [7:0]       reg_addr = 8'h00;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic             rate_sw = 1'b0;
    logic [11:0]      rate_num = '0;
    logic [11:0]      rate_den = '0;
    logic [CNT_W-1:0] count;
    logic             tick;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frac_rate_counter i_frac_rate_counter (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rate_sw   (rate_sw),
        .rate_num  (rate_num),
        .rate_den  (rate_den),
        .count     (count),
        .tick      (tick)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic switch_rate(input logic [11:0] n, input logic [11:0] d);
        rate_sw = 1'b1; rate_num = n; rate_den = d;
        @(negedge clk);
        rate_sw = 1'b0;
    endtask

    // Runs n clocks; checks step size and tick pairing each cycle (R3)
    task automatic run(input int n, output longint ticks);
        int bad = 0;
        ticks = 0;
        for (int i = 0; i < n; i++) begin
            logic [CNT_W-1:0] prev;
            prev = count;
            @(negedge clk);
            if (tick) ticks++;
            if (!((count == prev && !tick) || (count == prev + 1 && tick))) bad++;
        end
        check(bad == 0, "R3 step<=1 and tick pairing", 64'(bad), 64'd0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(count == '0, "R1 count after reset", count, 0);
        check(tick == 1'b0, "R1 tick after reset", 64'(tick), 0);
        reg_read(8'h10, d);
        check(d == 32'h4, "R1 numerator reset value", 64'(d), 64'h4);
        reg_read(8'h14, d);
        check(d == 32'h19, "R1 denominator reset value", 64'(d), 64'h19);
    endtask

    task automatic t_default();
        longint t;
        run(1000, t);
        check(count == 64'd160, "R2 default 4/25 over 1000 clocks", count, 160);
        check(t == 160, "R3 tick count equals advance", 64'(t), 160);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        logic [63:0] c0;
        longint t;
        reg_write(8'h10, 32'hABCDE008);
        reg_write(8'h14, 32'h13579019);
        c0 = count;
        run(500, t);
        check(count == c0 + 160, "R4 8/25 with upper bits set", count, c0 + 160);
        reg_read(8'h10, d);
        check(d == 32'hABCDE008, "R4 numerator readback", 64'(d), 64'hABCDE008);
        reg_read(8'h14, d);
        check(d == 32'h13579019, "R4 denominator readback", 64'(d), 64'h13579019);
    endtask

    task automatic t_switch();
        logic [31:0] dold, d;
        logic [63:0] c0;
        longint t;
        reg_read(8'h14, dold);
        reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = 32'h12345001;
        rate_sw = 1'b1; rate_num = 12'd3; rate_den = 12'd9;
        @(negedge clk);
        reg_wr = 1'b0; rate_sw = 1'b0;
        c0 = count;
        run(900, t);
        check(count == c0 + 300, "R6 switched ratio 3/9", count, c0 + 300);
        reg_read(8'h10, d);
        check(d == 32'h12345003, "R6 strobe wins low bits, write keeps upper", 64'(d), 64'h12345003);
        reg_read(8'h14, d);
        check(d == {dold[31:12], 12'd9}, "R6 denominator upper bits kept", 64'(d), 64'({dold[31:12], 12'd9}));
    endtask

    task automatic t_clear();
        logic [63:0] c0;
        longint t;
        switch_rate(12'd4, 12'd25);
        c0 = count;
        run(6, t);
        check(count == c0, "R5 no step in first 6 clocks", count, c0);
        switch_rate(12'd4, 12'd25);
        check(count == c0 + 1, "R5 load edge still steps by old ratio", count, c0 + 1);
        run(6, t);
        check(count == c0 + 1, "R5 remainder cleared on load", count, c0 + 1);
        run(1, t);
        check(count == c0 + 2, "R5 seventh clock after load steps", count, c0 + 2);
        switch_rate(12'd4, 12'd25);
        c0 = count;
        switch_rate(12'd25, 12'd25);
        check(count == c0, "R5 new ratio not used on its load edge", count, c0);
        run(1, t);
        check(count == c0 + 1, "R5 new ratio used on next edge", count, c0 + 1);
    endtask

    task automatic t_clamp();
        logic [63:0] c0;
        longint t;
        switch_rate(12'd100, 12'd50);
        c0 = count;
        run(20, t);
        check(count == c0 + 20, "R7 numerator above denominator", count, c0 + 20);
        switch_rate(12'd5, 12'd0);
        c0 = count;
        run(20, t);
        check(count == c0 + 20, "R7 zero denominator", count, c0 + 20);
    endtask

    task automatic t_stray();
        logic [63:0] c0;
        logic [31:0] d;
        longint t;
        switch_rate(12'd4, 12'd25);
        c0 = count;
        run(6, t);
        reg_write(8'h18, 32'hFFFFFFFF);
        run(18, t);
        check(count == c0 + 4, "R8 stray write leaves remainder", count, c0 + 4);
        reg_read(8'h18, d);
        check(d == 32'h0, "R8 unmapped read is zero", 64'(d), 0);
        reg_read(8'h10, d);
        check(d[11:0] == 12'd4, "R8 numerator untouched", 64'(d[11:0]), 4);
        reg_read(8'h14, d);
        check(d[11:0] == 12'd25, "R8 denominator untouched", 64'(d[11:0]), 25);
    endtask

    task automatic t_pair(input int n, input int d, input int clocks);
        logic [63:0] c0, exp;
        longint t;
        reg_write(8'h10, 32'(n));
        reg_write(8'h14, 32'(d));
        c0 = count;
        run(clocks, t);
        exp = c0 + 64'((longint'(clocks) * n) / d);
        check(count == exp, $sformatf("R2 ratio %0d/%0d over %0d clocks", n, d, clocks), count, exp);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_default();
        t_regs();
        t_switch();
        t_clear();
        t_clamp();
        t_stray();
        t_pair(768, 1625, 3257);
        t_pair(256, 1125, 2251);
        t_pair(192, 625, 1311);
        t_pair(64, 125, 253);
        t_pair(384, 1625, 1632);
        t_pair(8, 25, 777);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule